// File: doc/BRIEF.md
# Rotating-Parity Block Array Write Controller

This block sits in front of five block-addressed disk ports and presents them to a host as one array of logical blocks. Each logical block number is placed on one data disk inside a stripe, and the parity block of every stripe sits on a disk that changes from stripe to stripe. Spreading parity this way means that small writes to neighbouring stripes do not all queue on the same disk.

A one-block host write is carried out as a read-modify-write. The controller reads the old data and the old parity, then writes the new data, then writes the new parity. The new parity is the old parity XOR the old data XOR the new data.

A host read normally touches only the disk that holds the block. When the failed-disk mask marks that disk, the controller reads the other four blocks of the stripe one after another and returns their XOR. Each disk port moves one block of eight 32-bit words per operation, with one request/acknowledge beat per word. Only one host request is handled at a time.

Top module: `rpar_ctrl`

## Requirements
- R1: The stripe is the logical block number divided by 4, and the position inside the stripe is the remainder. The parity disk of stripe s is 4 - (s mod 5). Positions 0..3 take the non-parity disks in ascending disk order. `dsk_stripe` carries the stripe during every operation.
- R2: A host write issues exactly four block operations, in this order: read the data disk, read the parity disk, write the data disk, write the parity disk. No other disk is accessed.
- R3: After a write, the parity block of the stripe equals old parity XOR old data XOR new data, so it equals the XOR of the four data blocks of that stripe.
- R4: After a write, the data disk holds the new block, with word k taken from `req_wdata[32k+31:32k]`.
- R5: `done` is high for exactly one cycle, after the final acknowledge of the last operation. `busy` is high from the cycle after acceptance through the `done` cycle, and it is low on the following cycle.
- R6: With no failed disk marked at the target, a host read performs one read of the data disk and returns that block on `rsp_data`, word k in bits 32k+31:32k.
- R7: When `fail_mask` marks the target data disk, a read fetches the other four disks of the stripe in ascending disk order. It returns the XOR of their blocks, which equals the lost block.
- R8: A failed mark on a disk other than the target leaves a read unchanged: one read of the data disk, with the correct block returned.
- R9: At most one disk request is active in any cycle, and a disk marked failed is never requested.
- R10: `req_valid` is ignored while `busy` is high. Neither the operations issued nor any other block is affected.
- R11: In a block operation `dsk_word` counts 0 to 7, advancing only on an acknowledge of the requested disk. The request, the word index and the write word hold steady until that acknowledge arrives.
- R12: After reset, `busy`, `done` and `dsk_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request, accepted when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lba | input | 5 | Logical block number |
| req_wdata | input | 256 | Write block, word k in bits 32k+31:32k |
| fail_mask | input | 5 | One bit per disk marking it failed (at most one set) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 256 | Read block, valid at `done` of a read |
| dsk_req | output | 5 | One-hot block-operation request per disk |
| dsk_we | output | 1 | Operation is a write |
| dsk_stripe | output | 5 | Stripe (block address on the disk) |
| dsk_word | output | 3 | Word index within the block |
| dsk_wdata | output | 32 | Write word |
| dsk_ack | input | 5 | Per-disk word acknowledge |
| dsk_rdata | input | 160 | Per-disk read word, disk d in bits 32d+31:32d |

## Verification
The assertions rely on a few conditions on the inputs. `fail_mask` never marks more than one disk, and it does not change while `busy` is high. Writes are only requested when no disk is marked failed. A disk acknowledges only while it is being requested. The bench meets these conditions by changing the mask only between requests with the block idle, and by issuing all writes before any mask is set. Its disk models also raise an acknowledge only for the disk that is requested, stalling on a fixed per-disk pattern.

// File: rtl/rpar_pkg.sv
package rpar_pkg;

    localparam int unsigned DISKS_DEF  = 5;
    localparam int unsigned WORDS_DEF  = 8;
    localparam int unsigned WORD_W_DEF = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_RD_DATA,
        ST_RD_PAR,
        ST_WR_DATA,
        ST_WR_PAR,
        ST_RD_PEER,
        ST_DONE
    } seq_state_e;

    // first disk index at or after 'from' that is not marked failed
    // (at most one disk is ever marked)
    function automatic int skip_failed(input int from, input logic [31:0] mask);
        int i;
        i = from;
        if (i < 32 && mask[i]) i = i + 1;
        return i;
    endfunction

endpackage

// File: rtl/rpar_map.sv
module rpar_map #(
    parameter int NDISK  = 5,
    parameter int LBA_W  = 5,
    parameter int DIDX_W = 3
) (
    input  logic [LBA_W-1:0]  lba,
    output logic [LBA_W-1:0]  stripe,
    output logic [DIDX_W-1:0] data_disk,
    output logic [DIDX_W-1:0] parity_disk
);
    localparam int NDATA = NDISK - 1;

    int s_i, pos_i, p_i, d_i;

    always_comb begin
        s_i   = int'(lba) / NDATA;
        pos_i = int'(lba) % NDATA;
        p_i   = (NDISK - 1) - (s_i % NDISK);
        d_i   = (pos_i < p_i) ? pos_i : pos_i + 1;
        stripe      = LBA_W'(s_i);
        data_disk   = DIDX_W'(d_i);
        parity_disk = DIDX_W'(p_i);
    end

endmodule

// File: rtl/rpar_xacc.sv
module rpar_xacc #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      xor_en,
    input  logic [IDX_W-1:0]          idx,
    input  logic [WORD_W-1:0]         din,
    output logic [WORDS*WORD_W-1:0]   acc_flat,
    output logic [WORD_W-1:0]         acc_word
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst || clr)
                q <= '0;
            else if (xor_en && idx == IDX_W'(g))
                q <= q ^ din;
        end
        assign acc_flat[g*WORD_W +: WORD_W] = q;
    end

    assign acc_word = acc_flat[int'(idx)*WORD_W +: WORD_W];

endmodule

// File: rtl/rpar_seq.sv
module rpar_seq
    import rpar_pkg::*;
#(
    parameter int NDISK  = 5,
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    parameter int LBA_W  = 5,
    parameter int DIDX_W = 3,
    parameter int WIDX_W = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [LBA_W-1:0]          req_lba,
    input  logic [WORDS*WORD_W-1:0]   req_wdata,
    input  logic [NDISK-1:0]          fail_mask,
    output logic                      busy,
    output logic                      done,
    output logic [LBA_W-1:0]          lba_q,
    input  logic [DIDX_W-1:0]         data_disk,
    input  logic [DIDX_W-1:0]         parity_disk,
    output logic                      acc_clr,
    output logic                      acc_xor,
    output logic [WORD_W-1:0]         acc_din,
    input  logic [WORD_W-1:0]         acc_word,
    output logic [NDISK-1:0]          dsk_req,
    output logic                      dsk_we,
    output logic [WIDX_W-1:0]         dsk_word,
    output logic [WORD_W-1:0]         dsk_wdata,
    input  logic [NDISK-1:0]          dsk_ack,
    input  logic [NDISK*WORD_W-1:0]   dsk_rdata
);
    seq_state_e st_q, st_d;
    logic                    wr_q;
    logic [WORDS*WORD_W-1:0] wblk_q;
    logic [NDISK-1:0]        fail_q;
    logic [WIDX_W-1:0]       word_q;
    logic [DIDX_W-1:0]       peer_q, peer_d;
    logic [DIDX_W-1:0]       cur_disk;
    logic                    rd_state, active, beat, last_beat, accept;
    logic [WORD_W-1:0]       rword, wword;
    int                      first_peer, next_peer;

    assign accept   = (st_q == ST_IDLE) && req_valid;
    assign rd_state = (st_q == ST_RD_DATA) || (st_q == ST_RD_PAR) || (st_q == ST_RD_PEER);
    assign active   = rd_state || (st_q == ST_WR_DATA) || (st_q == ST_WR_PAR);

    always_comb begin
        case (st_q)
            ST_RD_PAR, ST_WR_PAR: cur_disk = parity_disk;
            ST_RD_PEER:           cur_disk = peer_q;
            default:              cur_disk = data_disk;
        endcase
    end

    assign dsk_req   = active ? (NDISK'(1) << cur_disk) : '0;
    assign dsk_we    = (st_q == ST_WR_DATA) || (st_q == ST_WR_PAR);
    assign dsk_word  = word_q;
    assign beat      = |(dsk_req & dsk_ack);
    assign last_beat = beat && (word_q == WIDX_W'(WORDS - 1));
    assign rword     = dsk_rdata[int'(cur_disk)*WORD_W +: WORD_W];
    assign wword     = wblk_q[int'(word_q)*WORD_W +: WORD_W];
    assign dsk_wdata = (st_q == ST_WR_PAR) ? acc_word : wword;

    // reads fold returned words in; the data write folds the new data in,
    // which turns old-data ^ old-parity into the new parity
    assign acc_clr = accept;
    assign acc_xor = beat && (rd_state || st_q == ST_WR_DATA);
    assign acc_din = rd_state ? rword : wword;

    assign first_peer = skip_failed(0, 32'(fail_q));
    assign next_peer  = skip_failed(int'(peer_q) + 1, 32'(fail_q));

    always_comb begin
        st_d   = st_q;
        peer_d = peer_q;
        case (st_q)
            ST_IDLE: if (req_valid) st_d = ST_PLAN;
            ST_PLAN: begin
                if (!wr_q && fail_q[data_disk]) begin
                    st_d   = ST_RD_PEER;
                    peer_d = DIDX_W'(first_peer);
                end else begin
                    st_d = ST_RD_DATA;
                end
            end
            ST_RD_DATA: if (last_beat) st_d = wr_q ? ST_RD_PAR : ST_DONE;
            ST_RD_PAR:  if (last_beat) st_d = ST_WR_DATA;
            ST_WR_DATA: if (last_beat) st_d = ST_WR_PAR;
            ST_WR_PAR:  if (last_beat) st_d = ST_DONE;
            ST_RD_PEER: begin
                if (last_beat) begin
                    if (next_peer >= NDISK) st_d = ST_DONE;
                    else                    peer_d = DIDX_W'(next_peer);
                end
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            peer_q <= '0;
            word_q <= '0;
            wr_q   <= 1'b0;
            lba_q  <= '0;
            wblk_q <= '0;
            fail_q <= '0;
        end else begin
            st_q   <= st_d;
            peer_q <= peer_d;
            if (beat)
                word_q <= last_beat ? '0 : word_q + 1'b1;
            if (accept) begin
                wr_q   <= req_write;
                lba_q  <= req_lba;
                wblk_q <= req_wdata;
                fail_q <= fail_mask;
            end
        end
    end

    assign busy = (st_q != ST_IDLE);
    assign done = (st_q == ST_DONE);

    // R5
    done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R10
    start_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

    // R11
    beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (|dsk_req && !beat) |=> ($stable(dsk_req) && $stable(dsk_word) && $stable(dsk_wdata)));

    // R2
    write_after_reads_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dsk_we) |-> $past(st_q == ST_RD_PAR));

endmodule

// File: rtl/rpar_ctrl.sv
module rpar_ctrl
    import rpar_pkg::*;
#(
    parameter int NDISK  = DISKS_DEF,
    parameter int WORDS  = WORDS_DEF,
    parameter int WORD_W = WORD_W_DEF,
    parameter int LBA_W  = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [LBA_W-1:0]          req_lba,
    input  logic [WORDS*WORD_W-1:0]   req_wdata,
    input  logic [NDISK-1:0]          fail_mask,
    output logic                      busy,
    output logic                      done,
    output logic [WORDS*WORD_W-1:0]   rsp_data,
    output logic [NDISK-1:0]          dsk_req,
    output logic                      dsk_we,
    output logic [LBA_W-1:0]          dsk_stripe,
    output logic [$clog2(WORDS)-1:0]  dsk_word,
    output logic [WORD_W-1:0]         dsk_wdata,
    input  logic [NDISK-1:0]          dsk_ack,
    input  logic [NDISK*WORD_W-1:0]   dsk_rdata
);
    localparam int DIDX_W = $clog2(NDISK);
    localparam int WIDX_W = $clog2(WORDS);

    logic [LBA_W-1:0]  lba_q;
    logic [DIDX_W-1:0] data_disk, parity_disk;
    logic              acc_clr, acc_xor;
    logic [WORD_W-1:0] acc_din, acc_word;

    rpar_map #(.NDISK(NDISK), .LBA_W(LBA_W), .DIDX_W(DIDX_W)) u_map (
        .lba         (lba_q),
        .stripe      (dsk_stripe),
        .data_disk   (data_disk),
        .parity_disk (parity_disk)
    );

    rpar_xacc #(.WORDS(WORDS), .WORD_W(WORD_W), .IDX_W(WIDX_W)) u_xacc (
        .clk      (clk),
        .rst      (rst),
        .clr      (acc_clr),
        .xor_en   (acc_xor),
        .idx      (dsk_word),
        .din      (acc_din),
        .acc_flat (rsp_data),
        .acc_word (acc_word)
    );

    rpar_seq #(
        .NDISK(NDISK), .WORDS(WORDS), .WORD_W(WORD_W),
        .LBA_W(LBA_W), .DIDX_W(DIDX_W), .WIDX_W(WIDX_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_lba     (req_lba),
        .req_wdata   (req_wdata),
        .fail_mask   (fail_mask),
        .busy        (busy),
        .done        (done),
        .lba_q       (lba_q),
        .data_disk   (data_disk),
        .parity_disk (parity_disk),
        .acc_clr     (acc_clr),
        .acc_xor     (acc_xor),
        .acc_din     (acc_din),
        .acc_word    (acc_word),
        .dsk_req     (dsk_req),
        .dsk_we      (dsk_we),
        .dsk_word    (dsk_word),
        .dsk_wdata   (dsk_wdata),
        .dsk_ack     (dsk_ack),
        .dsk_rdata   (dsk_rdata)
    );

    // R9
    one_disk_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dsk_req));

    // R9
    failed_untouched_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(dsk_req & fail_mask)));

    // R9
    single_fail_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fail_mask));

endmodule

// File: tb/rpar_ctrl_tb.sv
module rpar_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ND   = 5;
    localparam int NW   = 8;
    localparam int WW   = 32;
    localparam int LW   = 5;
    localparam int NSTR = 8;
    localparam int NLBA = 32;
    localparam int BW   = NW * WW;

    logic clk = 1'b0;
    logic rst;
    logic req_valid, req_write;
    logic [LW-1:0] req_lba;
    logic [BW-1:0] req_wdata;
    logic [ND-1:0] fail_mask;
    logic busy, done;
    logic [BW-1:0] rsp_data;
    logic [ND-1:0] dsk_req;
    logic dsk_we;
    logic [LW-1:0] dsk_stripe;
    logic [2:0] dsk_word;
    logic [WW-1:0] dsk_wdata;
    logic [ND-1:0] dsk_ack;
    logic [ND*WW-1:0] dsk_rdata;

    rpar_ctrl u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_lba(req_lba), .req_wdata(req_wdata), .fail_mask(fail_mask),
        .busy(busy), .done(done), .rsp_data(rsp_data), .dsk_req(dsk_req),
        .dsk_we(dsk_we), .dsk_stripe(dsk_stripe), .dsk_word(dsk_word),
        .dsk_wdata(dsk_wdata), .dsk_ack(dsk_ack), .dsk_rdata(dsk_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // disk models
    logic [WW-1:0] mem [ND][NSTR][NW];
    int log_disk [16];
    int log_we   [16];
    int log_str  [16];
    int log_n;
    int beat_cnt [ND];
    int proto_err;

    always @(negedge clk) begin
        logic [ND-1:0] a;
        for (int d = 0; d < ND; d++) begin
            a[d] = dsk_req[d] && (((cyc + d) % 3) != 1);
            if (a[d]) begin
                dsk_rdata[d*WW +: WW] = mem[d][int'(dsk_stripe)][int'(dsk_word)];
                if (int'(dsk_word) != beat_cnt[d]) proto_err++;
                if (dsk_we) mem[d][int'(dsk_stripe)][int'(dsk_word)] = dsk_wdata;
                beat_cnt[d]++;
                if (beat_cnt[d] == NW) begin
                    beat_cnt[d] = 0;
                    if (log_n < 16) begin
                        log_disk[log_n] = d;
                        log_we[log_n]   = int'(dsk_we);
                        log_str[log_n]  = int'(dsk_stripe);
                    end
                    log_n++;
                end
            end
        end
        dsk_ack = a;
    end

    logic [BW-1:0] lblk [NLBA];

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic void bmap(input int lba, output int s, output int d, output int p);
        int pos;
        s   = lba / 4;
        pos = lba % 4;
        p   = 4 - (s % 5);
        d   = (pos < p) ? pos : pos + 1;
    endfunction

    function automatic logic [BW-1:0] gen(input int lba, input int seed);
        logic [BW-1:0] b;
        for (int w = 0; w < NW; w++)
            b[w*WW +: WW] = (32'(lba) * 32'h0101_0003) ^ (32'(w) << 20)
                            ^ (32'(seed) * 32'h9E37_79B9) ^ 32'h5A00_00A5;
        return b;
    endfunction

    function automatic logic [BW-1:0] disk_blk(input int d, input int s);
        logic [BW-1:0] b;
        for (int w = 0; w < NW; w++) b[w*WW +: WW] = mem[d][s][w];
        return b;
    endfunction

    bit timed_out;

    task automatic run_req(input bit wr, input int lba, input logic [BW-1:0] blk, input bit jam);
        int n;
        @(negedge clk);
        log_n = 0; proto_err = 0; timed_out = 0;
        req_valid = 1'b1; req_write = wr; req_lba = LW'(lba); req_wdata = blk;
        @(negedge clk);
        if (jam) begin
            req_lba = LW'(lba ^ 1); req_wdata = ~blk; req_write = 1'b1;
            repeat (4) @(negedge clk);
        end
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            timed_out = 1;
            chk(0, "R5", "request timed out", 0, 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int s, d, p, s2, d2, p2;
        logic [BW-1:0] nb, par;
        rst = 1'b1; req_valid = 0; req_write = 0; req_lba = '0; req_wdata = '0;
        fail_mask = '0; dsk_ack = '0; dsk_rdata = '0; log_n = 0; proto_err = 0;
        for (int d0 = 0; d0 < ND; d0++) beat_cnt[d0] = 0;

        // initial array contents, parity consistent
        for (int l = 0; l < NLBA; l++) begin
            lblk[l] = gen(l, 0);
            bmap(l, s, d, p);
            for (int w = 0; w < NW; w++) mem[d][s][w] = lblk[l][w*WW +: WW];
        end
        for (int st = 0; st < NSTR; st++) begin
            p = 4 - (st % 5);
            for (int w = 0; w < NW; w++) begin
                mem[p][st][w] = '0;
                for (int dd = 0; dd < ND; dd++)
                    if (dd != p) mem[p][st][w] = mem[p][st][w] ^ mem[dd][st][w];
            end
        end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12
        chk(!busy && !done && dsk_req == '0, "R12", "reset state",
            {busy, done, dsk_req}, 0);

        // small-write sweep over every logical block, with requests jammed while busy
        for (int l = 0; l < NLBA; l++) begin
            bmap(l, s, d, p);
            nb = gen(l, 1);
            run_req(1, l, nb, 1);
            if (!timed_out) begin
                chk(log_n >= 1 && log_disk[0] == d && log_str[0] == s, "R1",
                    "write target disk/stripe", log_disk[0] * 16 + log_str[0], d * 16 + s);
                chk(log_n == 4 && log_disk[0] == d && log_we[0] == 0 &&
                    log_disk[1] == p && log_we[1] == 0 &&
                    log_disk[2] == d && log_we[2] == 1 &&
                    log_disk[3] == p && log_we[3] == 1 &&
                    log_str[1] == s && log_str[2] == s && log_str[3] == s,
                    "R2", "write op sequence", log_n, 4);
                chk(disk_blk(d, s) == nb, "R4", "data disk content", disk_blk(d, s), nb);
                par = '0;
                for (int dd = 0; dd < ND; dd++) if (dd != p) par = par ^ disk_blk(dd, s);
                chk(disk_blk(p, s) == par, "R3", "parity block", disk_blk(p, s), par);
                chk(proto_err == 0, "R11", "word index order", proto_err, 0);
                bmap(l ^ 1, s2, d2, p2);
                chk(disk_blk(d2, s2) == lblk[l ^ 1], "R10", "jammed block untouched",
                    disk_blk(d2, s2), lblk[l ^ 1]);
                @(negedge clk);
                chk(!busy && !done, "R5", "idle one cycle after done", {busy, done}, 0);
                lblk[l] = nb;
            end
        end

        // normal read sweep
        for (int l = 0; l < NLBA; l++) begin
            bmap(l, s, d, p);
            run_req(0, l, '0, 0);
            if (!timed_out) begin
                chk(rsp_data == lblk[l], "R6", "read data", rsp_data, lblk[l]);
                chk(log_n == 1 && log_disk[0] == d && log_we[0] == 0 && log_str[0] == s,
                    "R6", "single read op", log_n, 1);
                chk(proto_err == 0, "R11", "word index order", proto_err, 0);
            end
        end

        // reads with each disk marked failed
        for (int f = 0; f < ND; f++) begin
            @(negedge clk);
            fail_mask = ND'(1) << f;
            for (int l = 0; l < NLBA; l++) begin
                bmap(l, s, d, p);
                run_req(0, l, '0, 0);
                if (timed_out) continue;
                if (d == f) begin
                    bit ok;
                    int k;
                    chk(rsp_data == lblk[l], "R7", "rebuilt block", rsp_data, lblk[l]);
                    ok = (log_n == 4);
                    k = 0;
                    for (int dd = 0; dd < ND; dd++) begin
                        if (dd != f) begin
                            if (k < 4 && (log_disk[k] != dd || log_we[k] != 0 || log_str[k] != s))
                                ok = 0;
                            k++;
                        end
                    end
                    chk(ok, "R7", "peer read order", log_n, 4);
                    ok = 1;
                    for (int q = 0; q < 4 && q < log_n; q++) if (log_disk[q] == f) ok = 0;
                    chk(ok, "R9", "failed disk not accessed", f, -1);
                end else begin
                    chk(rsp_data == lblk[l], "R8", "read with other disk failed", rsp_data, lblk[l]);
                    chk(log_n == 1 && log_disk[0] == d, "R8", "single op on target",
                        log_n, 1);
                end
                chk(proto_err == 0, "R11", "word index order", proto_err, 0);
            end
        end

        @(negedge clk);
        fail_mask = '0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule